// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates an effective address to a real page address through a small set of block translation entries. Each entry is a pair of 32-bit words. The upper word describes which effective region the entry covers and which privilege levels may use it. The lower word gives the real block base and a 2-bit protection code. There are two independent banks of entries: one serves instruction fetches and the other serves data loads and stores.

Software loads the entries through a synchronous write port. A write names the bank, the entry index and the word. The lookup path is purely combinational. Each cycle it takes an effective address, a user/supervisor flag and a fetch/data flag. It reports whether some entry covers the address, the translated real page address and the rights granted. When several entries cover the same address, the entry with the lowest index wins.

Field positions that the matcher decodes:
- Upper word bits 31:17 hold the effective block index.
- Upper word bits 12:2 hold the block-length field.
- Upper word bit 1 is the supervisor-valid bit and bit 0 is the user-valid bit.
- Lower word bits 31:17 hold the real block index.
- Lower word bits 1:0 hold the protection code.

Top module: `bat_xlate_top`

## Requirements
- R1: After reset every entry word in both banks is zero, so no lookup hits until an entry has been written.
- R2: A write with `wr_en` high updates one word at the next rising clock edge, and the new value is used by lookups from the following cycle on. `wr_fetch_bank`=1 selects the instruction bank and 0 selects the data bank. `wr_lower`=1 selects the lower word and 0 selects the upper word.
- R3: An entry takes part in a user lookup (`user_mode`=1) only if upper bit 0 is set. It takes part in a supervisor lookup only if upper bit 1 is set.
- R4: The compare mask is 0xFFFE0000 with the length field (upper bits 12:2) moved up by 15 places and cleared out of it. Bits 31:28 are therefore always compared. An entry matches when the effective address ANDed with the mask equals upper bits 31:17, with the other bits taken as zero.
- R5: On a hit, `real_addr` takes its masked bit positions from the lower word and the remaining bit positions from the effective address. Bits 11:0 are forced to zero.
- R6: `prot` is encoded as bit 0 = read, bit 1 = write, bit 2 = execute. Protection code 0 grants nothing. Codes 1 and 3 grant read and execute. Code 2 grants read, write and execute.
- R7: A lookup with `is_fetch`=1 searches only the instruction bank. Any other lookup searches only the data bank.
- R8: When several entries match, the lowest-index one supplies `real_addr` and `prot`, even when its protection code grants nothing.
- R9: On a miss, `hit`, `real_addr` and `prot` are all zero.
- R10: A write changes only the addressed word of the addressed entry in the addressed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_fetch_bank | input | 1 | Write target bank: 1 instruction, 0 data |
| wr_idx | input | IDX_W | Entry index to write |
| wr_lower | input | 1 | Write target word: 1 lower, 0 upper |
| wr_data | input | 32 | Word value to write |
| ea | input | 32 | Effective address to translate |
| user_mode | input | 1 | 1 for a user access, 0 for supervisor |
| is_fetch | input | 1 | 1 for an instruction fetch, 0 for data |
| hit | output | 1 | Some usable entry covers the address |
| real_addr | output | 32 | Translated real page address |
| prot | output | 3 | Granted rights {exec, write, read} |

## Verification
Priority resolution between overlapping entries is the hardest case to reach from the ports. It shows only when two entries of the same bank cover one address and are both usable at the current privilege level.

The stimulus builds this case on purpose. It loads two overlapping instruction-bank entries whose protection codes differ. It then invalidates the lower one and checks that the answer moves to the higher entry.

A length field whose mask hides a nonzero effective-index bit is another case random data seldom hits. A directed entry covers it. A random phase then draws addresses and entry contents from a few regions so that partial masks and overlaps occur often. Every cycle is compared with a behavioural model.

// File: rtl/bat_pkg.sv
// Package: field positions and shared types for the block address
// translation matcher. Assumes 32-bit entry words and addresses.
package bat_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned EPI_LSB   = 17;
    localparam int unsigned LEN_LSB   = 2;
    localparam int unsigned LEN_MSB   = 12;
    localparam int unsigned LEN_SHIFT = 15;
    localparam int unsigned SUPV_BIT  = 1;
    localparam int unsigned USRV_BIT  = 0;
    localparam int unsigned PP_W      = 2;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t EPI_FIELD = ~((word_t'(1) << EPI_LSB) - word_t'(1));
    localparam word_t LEN_FIELD = ((word_t'(1) << (LEN_MSB + 1)) - word_t'(1))
                                  & ~((word_t'(1) << LEN_LSB) - word_t'(1));

    typedef struct packed {
        logic exec;
        logic wr;
        logic rd;
    } prot_t;

    // Turn a 2-bit protection code into the granted rights.
    function automatic prot_t decode_pp(input logic [PP_W-1:0] pp);
        prot_t p;
        p.rd   = (pp != '0);
        p.exec = (pp != '0);
        p.wr   = (pp == 2'd2);
        return p;
    endfunction

    // Compare mask of an entry: the index field minus the length bits.
    function automatic word_t block_mask(input word_t upper);
        return EPI_FIELD & ~((upper & LEN_FIELD) << LEN_SHIFT);
    endfunction
endpackage

// File: rtl/bat_entry_regs.sv
// Entry register file: two banks (data = 0, fetch = 1) of NUM_ENTRIES
// upper/lower word pairs, written one word per cycle and cleared by a
// synchronous active-low reset. Presents the bank picked by is_fetch.
module bat_entry_regs
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_fetch_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_lower,
    input  word_t            wr_data,
    input  logic             is_fetch,
    output word_t            sel_upper [NUM_ENTRIES],
    output word_t            sel_lower [NUM_ENTRIES]
);
    localparam int NUM_BANKS = 2;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        word_t bank_up [NUM_BANKS];
        word_t bank_lo [NUM_BANKS];

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            word_t up_q;
            word_t lo_q;
            logic  hit_me;

            // Decode whether this cycle's write targets this entry.
            assign hit_me = wr_en && (wr_fetch_bank == 1'(b))
                            && (wr_idx == IDX_W'(e));

            // Hold the upper word; clear on reset, load on a targeted write.
            always_ff @(posedge clk) begin
                if (!rst_n)                 up_q <= '0;
                else if (hit_me && !wr_lower) up_q <= wr_data;
            end

            // Hold the lower word; clear on reset, load on a targeted write.
            always_ff @(posedge clk) begin
                if (!rst_n)                lo_q <= '0;
                else if (hit_me && wr_lower) lo_q <= wr_data;
            end

            assign bank_up[b] = up_q;
            assign bank_lo[b] = lo_q;
        end

        assign sel_upper[e] = bank_up[is_fetch];
        assign sel_lower[e] = bank_lo[is_fetch];
    end
endmodule

// File: rtl/bat_entry_match.sv
// Single-entry matcher: checks privilege validity and the masked block
// compare, and forms this entry's real page address and rights.
// Purely combinational.
module bat_entry_match
    import bat_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  word_t upper,
    input  word_t lower,
    input  word_t ea,
    input  logic  user_mode,
    output logic  match,
    output word_t real_page,
    output prot_t prot
);
    localparam word_t PAGE_MASK = ~((word_t'(1) << PAGE_BITS) - word_t'(1));

    word_t mask;
    logic  usable;

    // Compare the masked address against the entry's block index.
    always_comb begin
        mask   = block_mask(upper);
        usable = user_mode ? upper[USRV_BIT] : upper[SUPV_BIT];
        match  = usable && ((ea & mask) == (upper & EPI_FIELD));
    end

    // Merge the block base with the in-block offset, aligned to a page.
    always_comb begin
        real_page = ((lower & mask) | (ea & ~mask)) & PAGE_MASK;
        prot      = decode_pp(lower[PP_W-1:0]);
    end
endmodule

// File: rtl/bat_prio_select.sv
// Priority selector: picks the lowest-index matching entry and passes
// its result on. All outputs are zero when nothing matches.
module bat_prio_select
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic [NUM_ENTRIES-1:0] match_vec,
    input  word_t                  real_in [NUM_ENTRIES],
    input  prot_t                  prot_in [NUM_ENTRIES],
    output logic                   hit,
    output logic [IDX_W-1:0]       sel_idx,
    output word_t                  real_out,
    output prot_t                  prot_out
);
    // Scan from the top down so that the lowest index is assigned last.
    always_comb begin
        hit     = |match_vec;
        sel_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) sel_idx = IDX_W'(i);
        end
    end

    // Steer the winner's result, or zeros on a miss.
    always_comb begin
        real_out = '0;
        prot_out = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (hit && (sel_idx == IDX_W'(i))) begin
                real_out = real_in[i];
                prot_out = prot_in[i];
            end
        end
    end
endmodule

// File: rtl/bat_xlate_top.sv
// Top of the block address translation matcher. Holds the entry banks,
// matches every entry of the selected bank in parallel and resolves
// priority. Assumes 32-bit addresses; lookups are combinational and a
// write becomes visible in the cycle after its clock edge.
module bat_xlate_top
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int PAGE_BITS   = 12,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_fetch_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_lower,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      ea,
    input  logic             user_mode,
    input  logic             is_fetch,
    output logic             hit,
    output logic [31:0]      real_addr,
    output logic [2:0]       prot
);
    word_t                  sel_upper [NUM_ENTRIES];
    word_t                  sel_lower [NUM_ENTRIES];
    word_t                  ent_real  [NUM_ENTRIES];
    prot_t                  ent_prot  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match_vec;
    logic [IDX_W-1:0]       sel_idx;
    word_t                  real_w;
    prot_t                  prot_w;

    bat_entry_regs #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_fetch_bank(wr_fetch_bank),
        .wr_idx       (wr_idx),
        .wr_lower     (wr_lower),
        .wr_data      (wr_data),
        .is_fetch     (is_fetch),
        .sel_upper    (sel_upper),
        .sel_lower    (sel_lower)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
        bat_entry_match #(.PAGE_BITS(PAGE_BITS)) i_match (
            .upper    (sel_upper[e]),
            .lower    (sel_lower[e]),
            .ea       (ea),
            .user_mode(user_mode),
            .match    (match_vec[e]),
            .real_page(ent_real[e]),
            .prot     (ent_prot[e])
        );
    end

    bat_prio_select #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) i_sel (
        .match_vec(match_vec),
        .real_in  (ent_real),
        .prot_in  (ent_prot),
        .hit      (hit),
        .sel_idx  (sel_idx),
        .real_out (real_w),
        .prot_out (prot_w)
    );

    assign real_addr = real_w;
    assign prot      = prot_w;
endmodule

// File: rtl/bat_xlate_chk.sv
// Checker for bat_xlate_top: relates the outputs to the match vector
// and the write history. Attached to the top module with bind.
module bat_xlate_chk #(
    parameter int NUM_ENTRIES = 4,
    parameter int PAGE_BITS   = 12,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   hit,
    input logic [31:0]            real_addr,
    input logic [2:0]             prot,
    input logic [NUM_ENTRIES-1:0] match_vec,
    input logic [IDX_W-1:0]       sel_idx
);
    logic                   any_wr_q;
    logic [NUM_ENTRIES-1:0] below_sel;

    // Remember whether any entry word has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     any_wr_q <= 1'b0;
        else if (wr_en) any_wr_q <= 1'b1;
    end

    assign below_sel = (NUM_ENTRIES'(1) << sel_idx) - NUM_ENTRIES'(1);

    // R1
    no_hit_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr_q |-> !hit);
    // R9
    miss_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (real_addr == '0 && prot == '0));
    // R6
    write_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && prot[1]) |-> (prot[0] && prot[2]));
    // R6
    exec_tracks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (prot[2] == prot[0]));
    // R5
    page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (real_addr[PAGE_BITS-1:0] == '0));
    // R8
    winner_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[sel_idx]);
    // R8
    nothing_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec & below_sel) == '0));
    // R4
    hit_iff_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit == ($countones(match_vec) != 0));
endmodule

bind bat_xlate_top bat_xlate_chk #(.NUM_ENTRIES(NUM_ENTRIES), .PAGE_BITS(PAGE_BITS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .hit      (hit),
    .real_addr(real_addr),
    .prot     (prot),
    .match_vec(match_vec),
    .sel_idx  (sel_idx)
);

// File: tb/test_bat_xlate_top.sv
module test_bat_xlate_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int IW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_fetch_bank = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_lower = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   ea = '0;
    logic          user_mode = 1'b0;
    logic          is_fetch = 1'b0;
    logic          hit;
    logic [31:0]   real_addr;
    logic [2:0]    prot;

    int tests = 0;
    int fails = 0;
    logic [31:0] ref_up [2][N];
    logic [31:0] ref_lo [2][N];

    always #(CLK_PERIOD/2) clk = ~clk;

    bat_xlate_top #(.NUM_ENTRIES(N)) i_bat_xlate_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fetch_bank(wr_fetch_bank),
        .wr_idx(wr_idx), .wr_lower(wr_lower), .wr_data(wr_data), .ea(ea),
        .user_mode(user_mode), .is_fetch(is_fetch), .hit(hit),
        .real_addr(real_addr), .prot(prot)
    );

    // Behavioural model of a lookup over the model's entry arrays.
    function automatic void ref_lookup(input logic [31:0] a, input bit usr, input bit fet,
                                       output bit h, output logic [31:0] ra,
                                       output logic [2:0] pr);
        int b = fet ? 1 : 0;
        h = 0; ra = '0; pr = '0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] up = ref_up[b][i];
            logic [31:0] lo = ref_lo[b][i];
            logic [31:0] msk = 32'hFFFE_0000 & ~{4'b0, up[12:2], 17'b0};
            bit ok = usr ? up[0] : up[1];
            if (!h && ok && ((a & msk) == (up & 32'hFFFE_0000))) begin
                h  = 1;
                ra = ((lo & msk) | (a & ~msk)) & 32'hFFFF_F000;
                case (lo[1:0])
                    2'd0:    pr = 3'b000;
                    2'd2:    pr = 3'b111;
                    default: pr = 3'b101;
                endcase
            end
        end
    endfunction

    task automatic clear_model();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < N; i++) begin ref_up[b][i] = '0; ref_lo[b][i] = '0; end
    endtask

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got hit/real/prot=%h expected %h", tag, got, exp);
        end
    endtask

    // Compare against the model on every clock after reset.
    always @(negedge clk) begin
        if (rst_n) begin
            bit h; logic [31:0] ra; logic [2:0] pr;
            ref_lookup(ea, user_mode, is_fetch, h, ra, pr);
            check("R4 R5 R6 model", {hit, real_addr, prot}, {h, ra, pr});
        end
    end

    // Write one entry word; the model follows at the same clock edge.
    task automatic wr(input bit fb, input int idx, input bit low, input logic [31:0] d);
        wr_en = 1; wr_fetch_bank = fb; wr_idx = IW'(idx); wr_lower = low; wr_data = d;
        @(posedge clk);
        if (low) ref_lo[fb][idx] = d; else ref_up[fb][idx] = d;
        #1 wr_en = 0;
    endtask

    // Apply a lookup and check it against literal expected values.
    task automatic look(input logic [31:0] a, input bit usr, input bit fet,
                        input bit eh, input logic [31:0] er, input logic [2:0] ep,
                        input string tag);
        ea = a; user_mode = usr; is_fetch = fet;
        @(negedge clk);
        check(tag, {hit, real_addr, prot}, {eh, er, ep});
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        clear_model();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: nothing hits straight after reset
        look(32'h0000_0000, 0, 0, 0, 0, 0, "R1 reset data");
        look(32'h1234_5678, 1, 1, 0, 0, 0, "R1 reset fetch");

        // Data entry 0: supervisor only, 128 KiB block, code 2
        wr(0, 0, 0, 32'h1000_0002);
        wr(0, 0, 1, 32'h8000_0002);
        look(32'h1001_2345, 0, 0, 1, 32'h8001_2000, 3'b111, "R2 R5 R6 sup hit");
        look(32'h1001_2345, 1, 0, 0, 0, 0, "R3 user blocked, R9 zeros");
        look(32'h1001_2345, 0, 1, 0, 0, 0, "R7 fetch misses data entry");

        // Data entry 1: user only, 256 MiB block, code 1
        wr(0, 1, 0, 32'h2000_1FFD);
        wr(0, 1, 1, 32'h5000_0001);
        look(32'h2ABC_DEF0, 1, 0, 1, 32'h5ABC_D000, 3'b101, "R4 full length mask");
        look(32'h2ABC_DEF0, 0, 0, 0, 0, 0, "R3 supervisor blocked");

        // Entry 2 index has a masked-out bit set; entry 3 is its clean twin
        wr(0, 2, 0, 32'h3002_0007);
        wr(0, 2, 1, 32'h6000_0002);
        wr(0, 3, 0, 32'h3000_0007);
        wr(0, 3, 1, 32'h7000_0003);
        look(32'h3003_4567, 0, 0, 1, 32'h7003_4000, 3'b101, "R4 hidden index bit, code3");

        // Instruction bank overlap: entry 0 code 0 beats entry 1 code 2
        wr(1, 0, 0, 32'h4000_0003);
        wr(1, 0, 1, 32'h9000_0000);
        wr(1, 1, 0, 32'h4000_0003);
        wr(1, 1, 1, 32'hA000_0002);
        look(32'h4000_1000, 1, 1, 1, 32'h9000_1000, 3'b000, "R8 low index wins");
        look(32'h4000_1000, 1, 0, 0, 0, 0, "R7 data misses fetch entry");
        wr(1, 0, 0, 32'h0000_0000);
        look(32'h4000_1000, 0, 1, 1, 32'hA000_1000, 3'b111, "R8 next entry after clear");

        // R10: the fetch-bank writes left data entry 0 untouched
        look(32'h1001_2345, 0, 0, 1, 32'h8001_2000, 3'b111, "R10 data entry intact");

        // Random phase with regions chosen to overlap often
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [31:0] d = $urandom;
                d[31:28] = 4'($urandom_range(1, 3));
                if ($urandom_range(0, 1) == 1) d[16:13] = '0;
                wr(1'($urandom_range(0, 1)), $urandom_range(0, N - 1),
                   1'($urandom_range(0, 1)), d);
            end else begin
                ea = $urandom;
                ea[31:28] = 4'($urandom_range(1, 3));
                user_mode = 1'($urandom_range(0, 1));
                is_fetch  = 1'($urandom_range(0, 1));
                @(posedge clk); #1;
            end
        end

        // R1: a second reset clears everything again
        do_reset();
        look(32'h1001_2345, 0, 0, 0, 0, 0, "R1 re-reset data");
        look(32'h4000_1000, 1, 1, 0, 0, 0, "R1 re-reset fetch");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule